// File: doc/BRIEF.md
# Serial-In Shift Register with Parallel Holding Latch

This block turns a serial bit stream into a parallel word. A chain of shift stages takes one bit per rising edge of its own shift clock. A separate holding register takes a snapshot of the whole chain on a rising edge of a second clock. The holding register drives the parallel outputs, so those outputs change only when the caller decides, however long it takes to load the new word.

The parallel outputs go high-impedance while the active-low enable is high. The last shift stage is always driven on a serial pin, so several blocks can be chained into a longer word. An active-low asynchronous clear empties the shift chain but leaves the holding register as it is.

Top module: `serial_latch_out`

## Requirements
- R1: On each rising edge of `shift_clk`, `ser_in` is captured into stage 0 and stage i moves into stage i+1 for every i below the last stage.
- R2: On each rising edge of `store_clk`, every shift stage is copied in one step into the holding register. Stage i goes to holding bit i.
- R3: When `shift_clk` and `store_clk` are the same signal, each edge stores the chain contents from just before that edge, so the holding register lags the chain by one shift.
- R4: While `clr_n` is low, all shift stages read zero at once, with no clock edge needed.
- R5: The holding register changes only on a rising edge of `store_clk`. A clear or a shift leaves it and the parallel outputs unchanged.
- R6: `ser_out` always equals the last shift stage and does not depend on `oe_n`.
- R7: While `oe_n` is low, `par_out[i]` drives holding bit i.
- R8: While `oe_n` is high, every bit of `par_out` is high-impedance, so another driver on the same net decides its value.
- R9: Two blocks with the first one's `ser_out` wired to the second one's `ser_in` form a 16-bit register. After 16 shifts and one store edge, with the word sent most significant bit first, `{second par_out, first par_out}` equals the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shift_clk | input | 1 | Shift chain clock, rising edge |
| store_clk | input | 1 | Holding register clock, rising edge |
| ser_in | input | 1 | Serial data into stage 0 |
| clr_n | input | 1 | Asynchronous clear of the shift chain, active low |
| oe_n | input | 1 | Parallel output enable, active low |
| par_out | output | STAGES | Holding register contents, or high-impedance |
| ser_out | output | 1 | Last shift stage, for chaining |

## Verification
The main test sweeps all 256 values of the low byte through a two-block chain. Each high byte is derived from its low byte, so every bit position carries both values on both sides of the chain link. This shows up a wrong stage order, a broken chain link or a swapped byte. Before each store edge the bench checks that the outputs still show the previous word. This separates a true holding latch from one that follows the shift chain. A run with the two clocks tied shows whether the store samples the chain before or after the edge. A clear with no clock edge, followed by a store edge, shows that the clear reaches the shift chain and does not reach the holding register. With the enable high, the bench drives the parallel net itself and checks that the serial pin keeps its value.

// File: rtl/slo_pkg.sv
package slo_pkg;
  localparam int unsigned SLO_STAGES_DEF = 8;
endpackage

// File: rtl/slo_shift_chain.sv
module slo_shift_chain #(
  parameter int unsigned W = slo_pkg::SLO_STAGES_DEF
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         din,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_stage
    logic nxt;
    if (i == 0) begin : g_head
      assign nxt = din;
    end else begin : g_body
      assign nxt = q[i-1];
    end
    always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) q[i] <= 1'b0;
      else        q[i] <= nxt;
    end
  end
endmodule

// File: rtl/slo_store_bank.sv
module slo_store_bank #(
  parameter int unsigned W = slo_pkg::SLO_STAGES_DEF
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    q <= d;
  end
endmodule

// File: rtl/slo_tri_drive.sv
module slo_tri_drive #(
  parameter int unsigned W = slo_pkg::SLO_STAGES_DEF
) (
  input  logic         oe_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] pad
);
  for (genvar i = 0; i < W; i++) begin : g_pad
    assign pad[i] = oe_n ? 1'bz : d[i];
  end
endmodule

// File: rtl/serial_latch_out.sv
module serial_latch_out #(
  parameter int unsigned STAGES = slo_pkg::SLO_STAGES_DEF
) (
  input  logic              shift_clk,
  input  logic              store_clk,
  input  logic              ser_in,
  input  logic              clr_n,
  input  logic              oe_n,
  output logic [STAGES-1:0] par_out,
  output logic              ser_out
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] st_q;

  slo_shift_chain #(.W(STAGES)) u_chain (
    .clk   (shift_clk),
    .clr_n (clr_n),
    .din   (ser_in),
    .q     (sh_q)
  );

  slo_store_bank #(.W(STAGES)) u_bank (
    .clk (store_clk),
    .d   (sh_q),
    .q   (st_q)
  );

  slo_tri_drive #(.W(STAGES)) u_drv (
    .oe_n (oe_n),
    .d    (st_q),
    .pad  (par_out)
  );

  assign ser_out = sh_q[LAST];
endmodule

// File: rtl/slo_checker.sv
module slo_checker #(
  parameter int unsigned W = slo_pkg::SLO_STAGES_DEF
) (
  input logic         shift_clk,
  input logic         store_clk,
  input logic         clr_n,
  input logic         ser_in,
  input logic [W-1:0] sh_q,
  input logic [W-1:0] st_q
);
  logic clr_pend = 1'b0;
  logic ran      = 1'b0;
  logic seen_st  = 1'b0;
  logic [W-1:0] snap = '0;

  always_ff @(posedge shift_clk or negedge clr_n) begin
    if (!clr_n) begin
      clr_pend <= 1'b1;
    end else begin
      clr_pend <= 1'b0;
      ran      <= ran | clr_pend;
    end
  end

  always_ff @(posedge store_clk) begin
    seen_st <= 1'b1;
    snap    <= sh_q;
  end

  // R1
  shift_adv_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
    (ran && !clr_pend) |-> (sh_q == {$past(sh_q[W-2:0]), $past(ser_in)}));

  // R4
  clear_zero_chk: assert property (@(posedge shift_clk) disable iff (!clr_n)
    clr_pend |-> (sh_q == '0));

  // R2
  store_copy_chk: assert property (@(posedge store_clk)
    seen_st |-> (st_q == snap));

  // R5
  store_hold_chk: assert property (@(posedge shift_clk)
    seen_st |-> (st_q == snap));
endmodule

bind serial_latch_out slo_checker #(.W(STAGES)) chk_i (
  .shift_clk (shift_clk),
  .store_clk (store_clk),
  .clr_n     (clr_n),
  .ser_in    (ser_in),
  .sh_q      (sh_q),
  .st_q      (st_q)
);

// File: tb/serial_latch_out_tb_top.sv
module serial_latch_out_tb_top;
  logic clk = 1'b0;
  logic shift_clk = 1'b0, store_clk = 1'b0, ser_in = 1'b0, clr_n = 1'b1, oe_n = 1'b0;
  logic tb_en = 1'b0;
  logic [7:0] tb_val = 8'h00;
  wire  [7:0] p0, p1;
  wire  so0, so1;
  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] m0 = 8'h00, m1 = 8'h00;

  always #5 clk = ~clk;

  assign p0 = tb_en ? tb_val : 8'hzz;

  serial_latch_out #(.STAGES(8)) dut_i (
    .shift_clk(shift_clk), .store_clk(store_clk), .ser_in(ser_in),
    .clr_n(clr_n), .oe_n(oe_n), .par_out(p0), .ser_out(so0));

  serial_latch_out #(.STAGES(8)) dut_b (
    .shift_clk(shift_clk), .store_clk(store_clk), .ser_in(so0),
    .clr_n(clr_n), .oe_n(oe_n), .par_out(p1), .ser_out(so1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_shift(input logic b);
    m1 = {m1[6:0], m0[7]};
    m0 = {m0[6:0], b};
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b; #2; shift_clk = 1'b1; #5; shift_clk = 1'b0; #3;
    model_shift(b);
  endtask

  task automatic store_pulse();
    #2; store_clk = 1'b1; #5; store_clk = 1'b0; #3;
  endtask

  task automatic tied_pulse(input logic b);
    ser_in = b; #2; shift_clk = 1'b1; store_clk = 1'b1; #5;
    shift_clk = 1'b0; store_clk = 1'b0; #3;
    model_shift(b);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int j = 15; j >= 0; j--) shift_bit(w[j]);
  endtask

  initial begin
    logic [15:0] prev;
    logic [15:0] w;
    #3;
    clr_n = 1'b0; #4; clr_n = 1'b1; m0 = 8'h00; m1 = 8'h00;
    store_pulse();
    // reset state after clear and store
    chk("R4 reset par", {p1, p0}, 16'h0000);
    chk("R6 reset ser", {so1, so0}, 2'b00);

    // R9 / R1 / R2 / R7 sweep over two chained blocks
    for (int v = 0; v < 256; v++) begin
      prev = {m1, m0};
      w = {8'(v) ^ 8'h5A ^ 8'(v << 3), 8'(v)};
      send_word(w);
      chk("R5 hold before store", {p1, p0}, prev);
      chk("R6 ser_out last stage", so1, w[15]);
      store_pulse();
      chk("R9 cascade word", {p1, p0}, w);
    end

    // R1 single-step shift positions
    send_word(16'h0000);
    store_pulse();
    shift_bit(1'b1);
    store_pulse();
    chk("R1 one into stage 0", {p1, p0}, 16'h0001);
    for (int k = 1; k < 16; k++) begin
      shift_bit(1'b0);
      store_pulse();
      chk("R1 walking one", {p1, p0}, 16'h0001 << k);
    end

    // R3 tied clocks: store lags chain by one shift
    for (int k = 0; k < 20; k++) begin
      prev = {m1, m0};
      tied_pulse(1'((k * 7 + 3) % 5 < 2));
      chk("R3 tied lag", {p1, p0}, prev);
    end

    // R4 / R5 clear without clock
    send_word(16'hC3A5);
    store_pulse();
    clr_n = 1'b0; #3;
    chk("R4 async clear ser", {so1, so0}, 2'b00);
    chk("R5 clear keeps store", {p1, p0}, 16'hC3A5);
    #3; clr_n = 1'b1; m0 = 8'h00; m1 = 8'h00; #4;
    chk("R5 store still held", {p1, p0}, 16'hC3A5);
    store_pulse();
    chk("R4 cleared chain stored", {p1, p0}, 16'h0000);

    // R8 / R6 output disable
    send_word(16'h80FF);
    store_pulse();
    chk("R7 enabled", p0, 8'hFF);
    oe_n = 1'b1; #2;
    tb_en = 1'b1; tb_val = 8'h00; #3;
    chk("R8 hiz low byte", p0, 8'h00);
    tb_val = 8'h3C; #3;
    chk("R8 hiz pattern", p0, 8'h3C);
    chk("R6 ser unaffected by oe_n", so1, 1'b1);
    tb_en = 1'b0; #2; oe_n = 1'b0; #3;
    chk("R7 re-enabled", {p1, p0}, 16'h80FF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule